// File: doc/BRIEF.md
# Serial Audio Receiver with Internal Bit Clock

This block takes a stereo serial audio stream on a single data line, framed by a frame clock whose level selects the channel, and turns it into parallel left and right sample words of up to 24 bits. The whole block runs on the master clock. It either derives its own bit-sampling instant by dividing the master clock or follows an external bit clock that it samples in the master clock domain. A mode flag from a neighbouring detector chooses between the two, and a ratio code from the same neighbour gives the master-to-frame ratio.

Three framings are supported and chosen by a format input. In the standard inter-IC sound framing the MSB follows the frame edge by one bit. In left-justified framing the MSB lands on the frame edge. The right-justified framing carries 16 bits that end at the close of each half-frame. Each complete stereo pair is presented with a one-cycle valid strobe, and both words change only in that cycle.

Top module: `ser_aud_rx`

## Requirements
- R1: While reset is held and right after it is released, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: In internal mode the number of bit periods per frame is 72 for ratio 1152, 48 for ratios 96, 192, 384 and 768, and otherwise 64 in left-justified format or 32 in the other formats. Each bit lasts ratio/bits-per-frame master clocks. Ratio codes: 0=64, 1=96, 2=128, 3=192, 4=256, 5=384, 6=512, 7=768, 8=1024, 9=1152.
- R3: Bits are taken MSB first as two's complement, one per bit-clock rising instant. With `fmt`=0 the MSB sits one bit period after the frame edge and the left channel is the half with `lrck` low.
- R4: With `fmt`=1 (left-justified, and also `fmt`=3) the MSB sits in the first bit period after the frame edge, the left channel is the half with `lrck` high, and bits past the 24th of a half-frame are ignored.
- R5: With `fmt`=2 the last 16 bits of each half-frame form the word, the left channel is `lrck` high, the word appears in bits 23:8, and bits 7:0 are zero. Earlier bits of the half-frame are ignored.
- R6: A word shorter than 24 bits is left-aligned in the output and its unused low bits are zero.
- R7: `valid_o` is high for exactly one master clock per frame, after the right word has been received, and the outputs hold their value in every other cycle.
- R8: With `ext_mode` high, bits are sampled on rising edges of `ext_bclk`, the divider is not used, and any number of bit periods per half-frame is accepted.
- R9: In internal mode the divider restarts on every `lrck` edge, so the bit periods line up with the frame whatever the divider phase was before.
- R10: Ratio codes 10 to 15 act as ratio 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Frame clock; its level selects the channel |
| sdin | input | 1 | Serial audio data |
| ext_bclk | input | 1 | External bit clock, synchronous to `clk` |
| ext_mode | input | 1 | 1 = follow `ext_bclk`, 0 = derive the bit clock internally |
| ratio_code | input | 4 | Master-to-frame ratio code (see R2, R10) |
| fmt | input | 2 | Framing: 0 inter-IC sound, 1 left-justified, 2 right-justified 16-bit |
| left_o | output | 24 | Left sample word, left-aligned |
| right_o | output | 24 | Right sample word, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is on the outputs |

## Verification
The hardest case to reach from the ports is the bit that crosses a half-frame boundary in the inter-IC sound framing at 32 bits per frame. There the LSB of one channel arrives after the frame clock has already changed to the other channel. The driver keeps the spill bit of each word and places it in slot 0 of the next half-frame. Before the first real frame it sends a lead-in at an odd divider phase, which covers both the spill bit and the resynchronisation. Padding bits past the word, and leading filler bits in the right-justified mode, are driven as ones so that any capture of them shows up in the compared words.

// File: rtl/ser_aud_rx_pkg.sv
package ser_aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ16 = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  // master clocks per frame for a ratio code; unknown codes fall back to 256
  function automatic int unsigned mclk_ratio(input logic [7:0] code);
    case (code)
      8'd0:    return 64;
      8'd1:    return 96;
      8'd2:    return 128;
      8'd3:    return 192;
      8'd4:    return 256;
      8'd5:    return 384;
      8'd6:    return 512;
      8'd7:    return 768;
      8'd8:    return 1024;
      8'd9:    return 1152;
      default: return 256;
    endcase
  endfunction

  // bit periods per frame of the internally generated bit clock
  function automatic int unsigned frame_bits(input logic [7:0] code, input fmt_e f);
    int unsigned r;
    r = mclk_ratio(code);
    if (r == 1152) return 72;
    if ((r % 3) == 0) return 48;
    if (f == FMT_LJ || f == FMT_RSVD) return 64;
    return 32;
  endfunction

  // master clocks per bit period
  function automatic int unsigned div_factor(input logic [7:0] code, input fmt_e f);
    return mclk_ratio(code) / frame_bits(code, f);
  endfunction

endpackage

// File: rtl/ser_aud_rx_bclk.sv
module ser_aud_rx_bclk #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck,
  input  logic             ext_mode,
  input  logic             ext_bclk,
  input  logic [CNT_W-1:0] div_n,
  output logic             bit_stb
);

  logic             lr_q;
  logic             eb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] phase;
  logic             lr_edge;
  logic             int_stb;
  logic             ext_rise;

  assign lr_edge = lrck ^ lr_q;

  // phase of the current master clock inside its bit period
  always_comb begin
    if (lr_edge)
      phase = '0;
    else if (cnt_q >= div_n - 1'b1)
      phase = '0;
    else
      phase = cnt_q + 1'b1;
  end

  // rising instant of the internal bit clock: middle of the period
  assign int_stb  = (phase == (div_n >> 1));
  assign ext_rise = ext_bclk & ~eb_q;
  assign bit_stb  = ext_mode ? ext_rise : int_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q  <= 1'b0;
      eb_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      lr_q  <= lrck;
      eb_q  <= ext_bclk;
      cnt_q <= phase;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < $past(div_n)); // R2

  AST_EDGE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_edge && !ext_mode) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/ser_aud_rx_word.sv
module ser_aud_rx_word
  import ser_aud_rx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RJ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              lrck,
  input  logic              sdin,
  input  fmt_e              fmt,
  output logic              done_o,
  output logic              done_left_o,
  output logic [WORD_W-1:0] done_data_o
);

  localparam int N_W = $clog2(WORD_W + 1);

  logic              l1_q, l2_q;
  logic              chan_q;
  logic              started_q;
  logic [WORD_W-1:0] sh_q;
  logic [N_W-1:0]    n_q;
  logic              is_i2s, is_rj;
  logic              chan_now;
  logic              word_start;
  logic              left_level;
  logic [WORD_W-1:0] aligned;

  assign is_i2s     = (fmt == FMT_I2S);
  assign is_rj      = (fmt == FMT_RJ16);
  // frame clock level that owns the current bit (one bit late in I2S)
  assign chan_now   = is_i2s ? l1_q : lrck;
  assign word_start = bit_stb && (is_i2s ? (l1_q != l2_q) : (lrck != l1_q));
  assign left_level = ~is_i2s;

  always_comb begin
    if (is_rj)
      aligned = {sh_q[RJ_W-1:0], {(WORD_W-RJ_W){1'b0}}};
    else
      aligned = sh_q << (WORD_W - n_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_q        <= 1'b0;
      l2_q        <= 1'b0;
      chan_q      <= 1'b0;
      started_q   <= 1'b0;
      sh_q        <= '0;
      n_q         <= '0;
      done_o      <= 1'b0;
      done_left_o <= 1'b0;
      done_data_o <= '0;
    end else begin
      done_o <= word_start && started_q;
      if (word_start) begin
        done_left_o <= (chan_q == left_level);
        done_data_o <= aligned;
      end
      if (bit_stb) begin
        l2_q <= l1_q;
        l1_q <= lrck;
        if (word_start) begin
          sh_q      <= {{(WORD_W-1){1'b0}}, sdin};
          n_q       <= N_W'(1);
          started_q <= 1'b1;
          chan_q    <= chan_now;
        end else if (is_rj || n_q < N_W'(WORD_W)) begin
          sh_q <= {sh_q[WORD_W-2:0], sdin};
          if (n_q < N_W'(WORD_W)) n_q <= n_q + 1'b1;
        end
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= N_W'(WORD_W)); // R6

  AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bit_stb)); // R3

endmodule

// File: rtl/ser_aud_rx.sv
module ser_aud_rx
  import ser_aud_rx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RJ_W   = 16,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrck,
  input  logic              sdin,
  input  logic              ext_bclk,
  input  logic              ext_mode,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic [1:0]        fmt,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  fmt_e              fmt_sel;
  logic [CNT_W-1:0]  div_n;
  logic              bit_stb;
  logic              wd_done;
  logic              wd_left;
  logic [WORD_W-1:0] wd_data;
  logic [WORD_W-1:0] left_pend_q;
  logic              have_left_q;

  assign fmt_sel = fmt_e'(fmt);
  assign div_n   = CNT_W'(div_factor(8'(ratio_code), fmt_sel));

  ser_aud_rx_bclk #(.CNT_W(CNT_W)) bclk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrck     (lrck),
    .ext_mode (ext_mode),
    .ext_bclk (ext_bclk),
    .div_n    (div_n),
    .bit_stb  (bit_stb)
  );

  ser_aud_rx_word #(.WORD_W(WORD_W), .RJ_W(RJ_W)) word_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .lrck        (lrck),
    .sdin        (sdin),
    .fmt         (fmt_sel),
    .done_o      (wd_done),
    .done_left_o (wd_left),
    .done_data_o (wd_data)
  );

  // pair the words: left waits until its right partner is complete
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_pend_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (wd_done) begin
        if (wd_left) begin
          left_pend_q <= wd_data;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= left_pend_q;
          right_o     <= wd_data;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

  AST_RJ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fmt_sel == FMT_RJ16) |->
      (left_o[WORD_W-RJ_W-1:0] == '0 && right_o[WORD_W-RJ_W-1:0] == '0)); // R5

endmodule

// File: tb/ser_aud_rx_tb_top.sv
module ser_aud_rx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0;
  logic        sdin = 1'b0;
  logic        ext_bclk = 1'b0;
  logic        ext_mode = 1'b0;
  logic [3:0]  ratio_code = 4'd4;
  logic [1:0]  fmt = 2'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    valid_prev = 0;
  string cur_req = "R3";
  logic [47:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_aud_rx dut_i (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .sdin(sdin), .ext_bclk(ext_bclk),
    .ext_mode(ext_mode), .ratio_code(ratio_code), .fmt(fmt),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ratio table per R2 / R10
  function automatic int tb_ratio(input logic [3:0] c);
    int t[10] = '{64, 96, 128, 192, 256, 384, 512, 768, 1024, 1152};
    return (c < 10) ? t[c] : 256;
  endfunction

  function automatic int tb_bpf(input logic [1:0] f, input logic [3:0] c);
    int r = tb_ratio(c);
    if (r == 96 || r == 192 || r == 384 || r == 768) return 48;
    if (r == 1152) return 72;
    return (f == 2'd1 || f == 2'd3) ? 64 : 32;
  endfunction

  function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [23:0] d, input int slots);
    int w;
    if (f == 2'd2) return {d[15:0], 8'h00};
    w = (slots < 24) ? slots : 24;
    return d & (24'hFFFFFF << (24 - w));
  endfunction

  // bit carried in slot k of a half-frame (I2S slot 0 handled by caller)
  function automatic logic slot_bit(input logic [1:0] f, input logic [23:0] d, input int k, input int slots);
    int idx;
    if (f == 2'd2) begin
      if (k < slots - 16) return 1'b1;
      return d[15 - (k - (slots - 16))];
    end
    idx = (f == 2'd0) ? k - 1 : k;
    return (idx < 24) ? d[23 - idx] : 1'b1;
  endfunction

  task automatic drive_slot(input logic lv, input logic b, input bit ext, input int n);
    @(negedge clk);
    lrck = lv; sdin = b; ext_bclk = 1'b0;
    if (ext) begin
      @(negedge clk); @(negedge clk); ext_bclk = 1'b1; @(negedge clk);
    end else begin
      repeat (n - 1) @(negedge clk);
    end
  endtask

  task automatic run_seq(input logic [1:0] f, input logic [3:0] c, input bit ext,
                         input int ext_slots, input int nfr, input string req);
    int bpf, ndiv, slots;
    logic left_lv, spill;
    logic [23:0] d, dl, dr;
    cur_req = req;
    bpf   = tb_bpf(f, c);
    ndiv  = tb_ratio(c) / bpf;
    slots = ext ? ext_slots : bpf / 2;
    left_lv = (f == 2'd0) ? 1'b0 : 1'b1;
    @(negedge clk);
    rst_n = 1'b0; fmt = f; ratio_code = c; ext_mode = ext;
    lrck = ~left_lv; sdin = 1'b0; ext_bclk = 1'b0;
    repeat (4) @(negedge clk);
    chk(left_o == 0 && right_o == 0 && !valid_o, "R1 in reset", {left_o, right_o}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(left_o == 0 && right_o == 0 && !valid_o, "R1 after release", {left_o, right_o}, 48'h0);
    // lead-in at the right-channel level, ending at an odd divider phase (R9)
    for (int i = 0; i < 3; i++) drive_slot(~left_lv, 1'b0, ext, ndiv);
    if (!ext) repeat (3) @(negedge clk);
    spill = 1'b0;
    for (int fr = 0; fr <= nfr; fr++) begin
      if (fr == 0)      begin dl = 24'h800000; dr = 24'h7FFFFF; end
      else if (fr < nfr) begin dl = 24'hA53C96 ^ (fr * 24'h1F3B7); dr = 24'h5AC369 ^ (fr * 24'h2C1D3); end
      else              begin dl = 24'h0; dr = 24'h0; end
      for (int h = 0; h < 2; h++) begin
        d = h ? dr : dl;
        for (int k = 0; k < slots; k++) begin
          if (f == 2'd0 && k == 0)
            drive_slot(h ? ~left_lv : left_lv, spill, ext, ndiv);
          else
            drive_slot(h ? ~left_lv : left_lv, slot_bit(f, d, k, slots), ext, ndiv);
        end
        spill = (slots - 1 < 24) ? d[23 - (slots - 1)] : 1'b1;
      end
      if (fr < nfr) exp_q.push_back({exp_word(f, dl, slots), exp_word(f, dr, slots)});
    end
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R7 one valid per frame", 48'(exp_q.size()), 48'h0);
    exp_q.delete();
  endtask

  // monitor: compare each presented pair against the scoreboard
  always @(negedge clk) begin
    logic [47:0] e;
    if (rst_n) begin
      if (valid_o && valid_prev)
        chk(1'b0, "R7 valid longer than one cycle", 48'h1, 48'h0);
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " unexpected valid"}, {left_o, right_o}, 48'h0);
        end else begin
          e = exp_q.pop_front();
          chk({left_o, right_o} == e, cur_req, {left_o, right_o}, e);
        end
      end
    end
    valid_prev = valid_o;
  end

  initial begin
    repeat (2) @(negedge clk);
    run_seq(2'd0, 4'd4,  1'b0, 0,  3, "R3 R6 R9 i2s 32fs");
    run_seq(2'd0, 4'd5,  1'b0, 0,  3, "R2 R3 i2s 48fs");
    run_seq(2'd0, 4'd8,  1'b0, 0,  2, "R2 R3 i2s ratio1024");
    run_seq(2'd1, 4'd0,  1'b0, 0,  3, "R2 R4 lj 64fs div1");
    run_seq(2'd1, 4'd9,  1'b0, 0,  3, "R2 R4 lj 72fs");
    run_seq(2'd2, 4'd6,  1'b0, 0,  3, "R5 rj 32fs");
    run_seq(2'd2, 4'd1,  1'b0, 0,  3, "R5 rj 48fs");
    run_seq(2'd1, 4'd7,  1'b1, 20, 3, "R8 R6 lj external");
    run_seq(2'd0, 4'd9,  1'b1, 32, 3, "R8 i2s external");
    run_seq(2'd1, 4'd12, 1'b0, 0,  3, "R10 code12 lj");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule